// File: doc/BRIEF.md
# Memory-Mapped General-Purpose Pin Controller

This block is a bank of general-purpose pins that software controls over an APB4 completer port. Software can set each pin to drive actively (push-pull) or to pull low only (open-drain). It can also set each pin's direction and output level, and read back the pin levels after they have been synchronised. The block drives a value bus and an output-enable bus, which the chip-level pad ring turns into bidirectional pads. An external source may change the pin inputs at any time. They pass through a flop chain clocked by the bus clock, and the last flop of that chain is the readable input register.

Three registers hold state and can be read and written: the per-bit mode, the per-bit direction and the output data. A fourth register is read-only and returns the synchronised inputs. The byte-lane strobes choose which bytes of a write land. Every transfer ends in its access phase with no wait states, and no transfer reports an error. A bus with no back-pressure suits this block: it has no data stream, only registers and pins, so no valid/ready handshake is added.

Top module: `gpio_bank_apb`

## Requirements
- R1: The register at word offset 0 holds the mode, offset 1 the direction and offset 2 the output data. All three can be read and written. Offset 3 returns the synchronised inputs. Read data appears on `prdata` while `psel` is high and `pwrite` is low, and is zero at all other times.
- R2: When `presetn` is low, mode, direction, output data and the input synchroniser all clear to zero. Every pin is then a push-pull input with `gpio_o` and `gpio_oe` at zero.
- R3: A bit with mode 0 is push-pull. Its `gpio_o` equals the output-data bit and its `gpio_oe` equals the direction bit, where 1 means drive and 0 means input.
- R4: A bit with mode 1 is open-drain. Its `gpio_o` is 0 and its `gpio_oe` is the inverse of the output-data bit. The direction bit has no effect on that pin but can still be read and written.
- R5: A level placed on `gpio_i` is returned by a read of offset 3 after exactly `STAGES` rising edges of `pclk`, and not after `STAGES-1` edges.
- R6: In a write, lane n covers bits 8n+7 down to 8n of `pwdata`. It updates the register only when `pstrb[n]` is 1, and lanes whose strobe is 0 keep their old value.
- R7: A register changes only at a rising edge where `psel`, `penable` and `pwrite` are all high. A setup phase alone writes nothing.
- R8: Writes to offset 3 and to any offset of 4 or higher leave every register unchanged. Reads of offsets 4 or higher return zero.
- R9: `pready` is always 1 and `pslverr` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Completer select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Word offset of the register |
| pwdata | input | DATA_W | Write data |
| pstrb | input | DATA_W/8 | Byte-lane write enables |
| prdata | output | DATA_W | Read data |
| pready | output | 1 | Transfer complete, held high |
| pslverr | output | 1 | Transfer error, held low |
| gpio_i | input | DATA_W | Pin levels from the pads, asynchronous |
| gpio_o | output | DATA_W | Value to the pad drivers |
| gpio_oe | output | DATA_W | Active-high pad driver enable |

## Verification
The assertions assume that a write exists only at an edge where `psel`, `penable` and `pwrite` are all high. They also assume that `paddr`, `pwdata` and `pstrb` are stable across that edge. The bench changes every input one nanosecond after a rising edge, so no input moves near an edge. It builds each transfer from a setup cycle followed by an access cycle. The pin inputs change only at those same points, which makes the synchroniser latency an exact edge count. One deliberate setup-only cycle is included to confirm that a transfer with no access phase writes nothing.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  // Word offsets of the register bank; the order is the address decode.
  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_OUT  = 2'd2,
    SEL_PIN  = 2'd3
  } gpio_sel_e;

  localparam int LANE_W = 8;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int W      = 8,
  parameter int STAGES = 3
) (
  input  logic         clk,
  input  logic         rstn,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  // The last flop of the chain is the readable input register.
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= '0;
    end else begin
      chain[0] <= din;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rstn,
  input  logic           wr_en,
  input  gpio_sel_e      wr_sel,
  input  logic [W-1:0]   wdata,
  input  logic [W/8-1:0] wstrb,
  output logic [W-1:0]   mode_q,
  output logic [W-1:0]   dir_q,
  output logic [W-1:0]   out_q
);
  localparam int LANES = W / LANE_W;

  logic [W-1:0] lane_mask;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign lane_mask[g*LANE_W +: LANE_W] = {LANE_W{wstrb[g]}};
    end
  endgenerate

  function automatic logic [W-1:0] merge(input logic [W-1:0] old_v,
                                         input logic [W-1:0] new_v,
                                         input logic [W-1:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction

  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) begin
      mode_q <= '0;
      dir_q  <= '0;
      out_q  <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_MODE: mode_q <= merge(mode_q, wdata, lane_mask);
        SEL_DIR:  dir_q  <= merge(dir_q,  wdata, lane_mask);
        SEL_OUT:  out_q  <= merge(out_q,  wdata, lane_mask);
        default:  ;
      endcase
    end
  end

  // R7: nothing moves without an access-phase write
  assert_no_write_hold_R7: assert property (@(posedge clk) disable iff (!rstn)
    !wr_en |=> ($stable(mode_q) && $stable(dir_q) && $stable(out_q)));

  // R8: the input offset is not writable
  assert_pin_ro_R8: assert property (@(posedge clk) disable iff (!rstn)
    (wr_en && wr_sel == SEL_PIN) |=> ($stable(mode_q) && $stable(dir_q) && $stable(out_q)));

  // R6: a cleared strobe keeps lane 0 of the output data
  assert_lane_keep_R6: assert property (@(posedge clk) disable iff (!rstn)
    (wr_en && wr_sel == SEL_OUT && !wstrb[0]) |=> out_q[LANE_W-1:0] == $past(out_q[LANE_W-1:0]));
endmodule

// File: rtl/gpio_bank_outmux.sv
module gpio_bank_outmux #(
  parameter int W = 8
) (
  input  logic [W-1:0] mode_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] out_q,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] pin_oe
);
  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      // open-drain: value pinned low, enable active when the data bit is 0
      assign pin_o[b]  = mode_q[b] ? 1'b0       : out_q[b];
      assign pin_oe[b] = mode_q[b] ? ~out_q[b]  : dir_q[b];
    end
  endgenerate
endmodule

// File: rtl/gpio_bank_apb.sv
module gpio_bank_apb
  import gpio_bank_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int STAGES = 3
) (
  input  logic                pclk,
  input  logic                presetn,
  input  logic                psel,
  input  logic                penable,
  input  logic                pwrite,
  input  logic [ADDR_W-1:0]   paddr,
  input  logic [DATA_W-1:0]   pwdata,
  input  logic [DATA_W/8-1:0] pstrb,
  output logic [DATA_W-1:0]   prdata,
  output logic                pready,
  output logic                pslverr,
  input  logic [DATA_W-1:0]   gpio_i,
  output logic [DATA_W-1:0]   gpio_o,
  output logic [DATA_W-1:0]   gpio_oe
);
  localparam int SEL_W = 2;
  localparam int HI_W  = ADDR_W - SEL_W;

  logic [DATA_W-1:0] mode_q, dir_q, out_q, pin_q;
  logic              mapped, wr_en;
  gpio_sel_e         sel;

  assign mapped = (paddr[ADDR_W-1:SEL_W] == {HI_W{1'b0}});
  assign sel    = gpio_sel_e'(paddr[SEL_W-1:0]);
  assign wr_en  = psel && penable && pwrite && mapped;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  gpio_bank_sync #(.W(DATA_W), .STAGES(STAGES)) u_sync (
    .clk (pclk),
    .rstn(presetn),
    .din (gpio_i),
    .dout(pin_q)
  );

  gpio_bank_regs #(.W(DATA_W)) u_regs (
    .clk   (pclk),
    .rstn  (presetn),
    .wr_en (wr_en),
    .wr_sel(sel),
    .wdata (pwdata),
    .wstrb (pstrb),
    .mode_q(mode_q),
    .dir_q (dir_q),
    .out_q (out_q)
  );

  gpio_bank_outmux #(.W(DATA_W)) u_mux (
    .mode_q(mode_q),
    .dir_q (dir_q),
    .out_q (out_q),
    .pin_o (gpio_o),
    .pin_oe(gpio_oe)
  );

  always_comb begin
    prdata = '0;
    if (psel && !pwrite && mapped) begin
      case (sel)
        SEL_MODE: prdata = mode_q;
        SEL_DIR:  prdata = dir_q;
        SEL_OUT:  prdata = out_q;
        SEL_PIN:  prdata = pin_q;
        default:  prdata = '0;
      endcase
    end
  end

  // R4: an open-drain bit never drives a one
  assert_od_low_R4: assert property (@(posedge pclk) disable iff (!presetn)
    (mode_q & gpio_o) == '0);

  // R4: open-drain enable is the inverted data bit
  assert_od_enable_R4: assert property (@(posedge pclk) disable iff (!presetn)
    (mode_q & (gpio_oe ^ ~out_q)) == '0);

  // R3: push-pull enable follows the direction bit
  assert_pp_enable_R3: assert property (@(posedge pclk) disable iff (!presetn)
    (~mode_q & (gpio_oe ^ dir_q)) == '0);
endmodule

// File: tb/tb_gpio_bank_apb.sv
`timescale 1ns/1ps
module tb_gpio_bank_apb;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int ST = 3;

  logic          pclk = 1'b0;
  logic          presetn = 1'b0;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pwdata = '0;
  logic [1:0]    pstrb = '0;
  logic [DW-1:0] prdata;
  logic          pready, pslverr;
  logic [DW-1:0] gpio_i = '0;
  logic [DW-1:0] gpio_o, gpio_oe;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  // shadow registers built from the requirements
  logic [DW-1:0] m_mode = '0, m_dir = '0, m_out = '0;

  always #10 pclk = ~pclk;

  gpio_bank_apb #(.DATA_W(DW), .ADDR_W(AW), .STAGES(ST)) dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb),
    .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .gpio_i(gpio_i), .gpio_o(gpio_o), .gpio_oe(gpio_oe)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] o, input logic [DW-1:0] d,
                                          input logic [1:0] s);
    logic [DW-1:0] m;
    m = {{8{s[1]}}, {8{s[0]}}};
    return (o & ~m) | (d & m);
  endfunction

  // monitor: one scoreboard item per completed read access
  always @(negedge pclk) begin
    if (psel && penable && !pwrite) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1 unexpected read actual=%h expected=none", prdata);
      end else begin
        chk(tag_q.pop_front(), prdata, exp_q.pop_front());
      end
    end
  end

  task automatic apb_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] s);
    @(posedge pclk); #1;
    psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d; pstrb = s;
    @(posedge pclk); #1 penable = 1;
    @(posedge pclk); #1 psel = 0; penable = 0; pwrite = 0; pstrb = '0;
    case (a)
      4'd0: m_mode = merge(m_mode, d, s);
      4'd1: m_dir  = merge(m_dir,  d, s);
      4'd2: m_out  = merge(m_out,  d, s);
      default: ;
    endcase
  endtask

  task automatic apb_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge pclk); #1;
    psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(posedge pclk); #1 penable = 1;
    @(posedge pclk); #1 psel = 0; penable = 0;
  endtask

  task automatic chk_pins(input string tag);
    chk({tag, " gpio_o"},  gpio_o,  m_out & ~m_mode);
    chk({tag, " gpio_oe"}, gpio_oe, (m_dir & ~m_mode) | (~m_out & m_mode));
  endtask

  task automatic finish_up;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge pclk);
    #1 presetn = 1;

    // R2 / R9: reset state
    chk("R2 reset gpio_o", gpio_o, '0);
    chk("R2 reset gpio_oe", gpio_oe, '0);
    chk("R9 pready", {15'd0, pready}, 16'd1);
    chk("R9 pslverr", {15'd0, pslverr}, 16'd0);
    apb_read(4'd0, 16'h0000, "R2 mode reset");
    apb_read(4'd1, 16'h0000, "R2 dir reset");
    apb_read(4'd2, 16'h0000, "R2 out reset");
    chk("R1 idle prdata", prdata, '0);

    // R1 / R3: push-pull
    apb_write(4'd1, 16'hA5C3, 2'b11);
    apb_write(4'd2, 16'h0FF0, 2'b11);
    apb_read(4'd1, 16'hA5C3, "R1 dir readback");
    apb_read(4'd2, 16'h0FF0, "R1 out readback");
    chk_pins("R3 push-pull");

    // R4: low byte open-drain
    apb_write(4'd0, 16'h00FF, 2'b11);
    apb_read(4'd0, 16'h00FF, "R1 mode readback");
    chk_pins("R4 open-drain mix");
    apb_write(4'd1, 16'hFFFF, 2'b11);
    chk_pins("R4 dir ignored in od");
    apb_read(4'd1, 16'hFFFF, "R4 dir still readable");

    // R6: byte strobes
    apb_write(4'd2, 16'h1234, 2'b01);
    apb_read(4'd2, 16'h0F34, "R6 low lane only");
    apb_write(4'd2, 16'hABCD, 2'b10);
    apb_read(4'd2, 16'hAB34, "R6 high lane only");
    apb_write(4'd2, 16'h0000, 2'b00);
    apb_read(4'd2, 16'hAB34, "R6 no lanes");
    chk_pins("R6 pins after strobes");

    // R7: setup phase without access
    @(posedge pclk); #1;
    psel = 1; pwrite = 1; penable = 0; paddr = 4'd2; pwdata = 16'h0000; pstrb = 2'b11;
    @(posedge pclk); #1 psel = 0; pwrite = 0; pstrb = '0;
    apb_read(4'd2, 16'hAB34, "R7 setup-only no write");

    // R8: input offset and unmapped offsets
    apb_write(4'd3, 16'hFFFF, 2'b11);
    apb_write(4'd5, 16'hFFFF, 2'b11);
    apb_write(4'd14, 16'h0000, 2'b11);
    apb_read(4'd0, 16'h00FF, "R8 mode untouched");
    apb_read(4'd1, 16'hFFFF, "R8 dir untouched");
    apb_read(4'd2, 16'hAB34, "R8 out untouched");
    apb_read(4'd7, 16'h0000, "R8 unmapped read zero");
    chk_pins("R8 pins untouched");

    // R5: synchroniser latency
    gpio_i = 16'h1111;
    repeat (ST + 2) @(posedge pclk);
    #1 psel = 1; pwrite = 0; penable = 0; paddr = 4'd3; gpio_i = 16'h5A3C;
    repeat (ST - 1) @(posedge pclk);
    #1 chk("R5 before latency", prdata, 16'h1111);
    @(posedge pclk);
    #1 chk("R5 at latency", prdata, 16'h5A3C);
    psel = 0;
    gpio_i = 16'hC3A5;
    apb_read(4'd3, 16'h5A3C, "R5 old value still in chain");
    repeat (ST) @(posedge pclk);
    apb_read(4'd3, 16'hC3A5, "R5 second pattern");

    // R4: all open-drain, all driven low
    apb_write(4'd0, 16'hFFFF, 2'b11);
    apb_write(4'd2, 16'h0000, 2'b11);
    chk_pins("R4 all od low");
    apb_write(4'd2, 16'hF00F, 2'b11);
    chk_pins("R4 all od mixed");

    // R3: back to push-pull
    apb_write(4'd0, 16'h0000, 2'b11);
    apb_write(4'd1, 16'h3C3C, 2'b11);
    chk_pins("R3 push-pull again");
    chk("R9 pready end", {15'd0, pready}, 16'd1);

    repeat (2) @(posedge pclk);
    finish_up();
  end
endmodule